// File: doc/BRIEF.md
# Chunk Window Commit Queue

This block sequences speculative work across several processing nodes. Work is cut into chunks, and each chunk is a fixed run of consecutive thread numbers. Whenever a node is idle it raises its request line. The block hands that node the next chunk number and the first thread number of the chunk, and places the chunk at the most-speculative end of an ordered window. Chunks in the window are always numbered consecutively. The oldest chunk, at the head, is the least speculative one.

Nodes report finished chunks by chunk number. Chunks retire only from the head, at most one per cycle, and each retirement grants the commit to the node that owns the chunk. A chunk that finishes early is only marked. It retires later without any further action from its node, so a run of finished chunks drains on consecutive cycles. A squash names a chunk in the window. That chunk and every younger chunk are dropped at once, and the dropped chunks are handed out again in order, starting from the named number. A programmed total bounds the run, and the block signals empty once every chunk up to that total has committed.

Top module: `chunk_window`

## Requirements
- R1: While reset is applied and after it, no chunk is assigned, no commit is granted, and `empty` is 1 until a run is started.
- R2: When one or more bits of `req` are set, the lowest-numbered requesting node is assigned. The chunk number is the next sequential number, and `assign_thread` equals chunk number times THREADS_PER_CHUNK. All of these appear combinationally in the request cycle.
- R3: While DEPTH chunks are active, no new chunk is assigned, even when requests are present.
- R4: No chunk is assigned once the next chunk number equals the programmed total.
- R5: Only the head chunk commits. When the head chunk is reported finished, `commit_valid` rises in that same cycle with the owner's node index and the chunk number, and the head advances by one.
- R6: A finish report for a chunk that is not the head produces no commit. When that chunk later becomes the head, it commits with no new report. Consecutive finished chunks commit on consecutive cycles, one per cycle.
- R7: A node may own several uncommitted chunks at once. It can be assigned a new chunk while an earlier finished chunk of its own still waits.
- R8: A squash of a chunk in the window removes that chunk and all younger ones. In the squash cycle, no assignment and no commit happen. The next assignment reuses the squashed chunk number, and later assignments continue in order from it.
- R9: A finish report naming a chunk outside the active window has no effect on later commits.
- R10: `empty` is 0 during a run that has uncommitted or unissued chunks, and becomes 1 on the cycle after the last chunk commits. While `empty` is 1, no commit is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run: clears the window and loads the total |
| total_chunks | input | CW | Number of chunks in the run |
| req | input | NODES | Idle nodes requesting a chunk |
| assign_valid | output | 1 | A chunk is handed out this cycle |
| assign_node | output | NW | Node receiving the chunk |
| assign_chunk | output | CW | Chunk number handed out |
| assign_thread | output | TW | First thread number of that chunk |
| done_valid | input | 1 | A node reports a finished chunk |
| done_chunk | input | CW | Number of the finished chunk |
| squash_valid | input | 1 | Squash request |
| squash_chunk | input | CW | Oldest chunk to discard |
| commit_valid | output | 1 | Head chunk commits this cycle |
| commit_node | output | NW | Owner of the committing chunk |
| commit_chunk | output | CW | Number of the committing chunk |
| empty | output | 1 | All chunks of the run have committed |

## Verification
The bench builds the block with three nodes, a window of four chunks, six-bit chunk numbers and four threads per chunk. The small window fills after four assignments, so the full hold-off and the wrap of slot indices are both reached within a few dozen cycles. Three nodes make it practical to have one node own two open chunks, and to create out-of-order finishes that retire as a burst. A total of ten chunks lets the run end and exposes the assignment limit and the empty flag.

// File: rtl/chunk_window.sv
module chunk_window #(
  parameter int NODES = 4,
  parameter int DEPTH = 8,
  parameter int CW = 8,
  parameter int THREADS_PER_CHUNK = 4,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int SW = $clog2(DEPTH),
  localparam int TW = CW + $clog2(THREADS_PER_CHUNK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] total_chunks,
  input  logic [NODES-1:0] req,
  output logic          assign_valid,
  output logic [NW-1:0] assign_node,
  output logic [CW-1:0] assign_chunk,
  output logic [TW-1:0] assign_thread,
  input  logic          done_valid,
  input  logic [CW-1:0] done_chunk,
  input  logic          squash_valid,
  input  logic [CW-1:0] squash_chunk,
  output logic          commit_valid,
  output logic [NW-1:0] commit_node,
  output logic [CW-1:0] commit_chunk,
  output logic          empty
);

  logic [CW-1:0]    head_q, next_q, total_q;
  logic [DEPTH-1:0] fin_q;
  logic [NW-1:0]    owner_q [DEPTH];

  logic [CW-1:0] count, done_off, sq_off;
  logic done_ok, sq_ok, head_done;
  logic [SW-1:0] head_slot, tail_slot;

  assign count     = next_q - head_q;
  assign done_off  = done_chunk - head_q;
  assign sq_off    = squash_chunk - head_q;
  assign done_ok   = done_valid && (done_off < count);
  assign sq_ok     = squash_valid && (sq_off < count);
  assign head_slot = head_q[SW-1:0];
  assign tail_slot = next_q[SW-1:0];
  assign head_done = fin_q[head_slot] || (done_ok && done_off == '0);

  assign commit_valid = (count != '0) && head_done && !squash_valid && !start;
  assign commit_node  = owner_q[head_slot];
  assign commit_chunk = head_q;
  assign empty        = (head_q == total_q);

  always_comb begin
    assign_node = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (req[i]) assign_node = NW'(i);
  end

  assign assign_valid  = (|req) && (count < CW'(DEPTH)) && (next_q < total_q)
                         && !squash_valid && !start;
  assign assign_chunk  = next_q;
  assign assign_thread = TW'(next_q) * TW'(THREADS_PER_CHUNK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      next_q  <= '0;
      total_q <= '0;
      fin_q   <= '0;
      for (int i = 0; i < DEPTH; i++) owner_q[i] <= '0;
    end else if (start) begin
      head_q  <= '0;
      next_q  <= '0;
      total_q <= total_chunks;
      fin_q   <= '0;
    end else begin
      if (done_ok && !(sq_ok && done_off >= sq_off))
        fin_q[done_chunk[SW-1:0]] <= 1'b1;
      if (commit_valid) begin
        fin_q[head_slot] <= 1'b0;
        head_q <= head_q + 1'b1;
      end
      if (assign_valid) begin
        fin_q[tail_slot]   <= 1'b0;
        owner_q[tail_slot] <= assign_node;
        next_q <= next_q + 1'b1;
      end
      if (sq_ok) next_q <= squash_chunk;
    end
  end

endmodule

// File: rtl/chunk_window_chk.sv
module chunk_window_chk #(
  parameter int DEPTH = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          squash_valid,
  input logic          assign_valid,
  input logic [CW-1:0] assign_chunk,
  input logic          commit_valid,
  input logic          empty,
  input logic [CW-1:0] head_q,
  input logic [CW-1:0] next_q
);

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(next_q - head_q) == CW'(DEPTH)) |-> !assign_valid);

  // R2
  seq_number_chk: assert property (@(posedge clk) disable iff (!rst_n)
    assign_valid |=> next_q == $past(assign_chunk) + 1'b1);

  // R5
  head_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> head_q == $past(head_q) + 1'b1);

  // R8
  squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> !(assign_valid || commit_valid));

  // R10
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !commit_valid);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !commit_valid && !assign_valid);

endmodule

bind chunk_window chunk_window_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .squash_valid(squash_valid),
  .assign_valid(assign_valid), .assign_chunk(assign_chunk),
  .commit_valid(commit_valid), .empty(empty),
  .head_q(head_q), .next_q(next_q)
);

// File: tb/sim_chunk_window.sv
`timescale 1ns/1ps
module sim_chunk_window;
  localparam int NODES = 3, DEPTH = 4, CW = 6, TPC = 4;
  localparam int NW = 2, TW = CW + 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [CW-1:0] total_chunks = '0;
  logic [NODES-1:0] req = '0;
  logic done_valid = 0, squash_valid = 0;
  logic [CW-1:0] done_chunk = '0, squash_chunk = '0;
  logic assign_valid, commit_valid, empty;
  logic [NW-1:0] assign_node, commit_node;
  logic [CW-1:0] assign_chunk, commit_chunk;
  logic [TW-1:0] assign_thread;

  int vecs = 0, fails = 0;
  logic [NW+CW-1:0] exp_q [$];
  bit finished = 0;

  always #2 clk = ~clk;

  chunk_window #(.NODES(NODES), .DEPTH(DEPTH), .CW(CW), .THREADS_PER_CHUNK(TPC)) u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NODES-1:0] r, input logic dv, input int dc,
                      input logic sv, input int sc);
    @(negedge clk);
    req = r; done_valid = dv; done_chunk = CW'(dc);
    squash_valid = sv; squash_chunk = CW'(sc);
    #1;
  endtask

  task automatic chk_assign(input int node, input int chunk, input string tag);
    chk({tag, " assign_valid"}, int'(assign_valid), 1);
    chk({tag, " assign_node"}, int'(assign_node), node);
    chk({tag, " assign_chunk"}, int'(assign_chunk), chunk);
    chk({tag, " assign_thread"}, int'(assign_thread), chunk * TPC);
  endtask

  task automatic push(input int node, input int chunk);
    exp_q.push_back({NW'(node), CW'(chunk)});
  endtask

  // scoreboard monitor for commit grants (R5, R6)
  always @(negedge clk) begin
    #1;
    if (rst_n && commit_valid && !finished) begin
      vecs++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6 unexpected commit actual=%0d/%0d expected=none",
                 commit_node, commit_chunk);
      end else begin
        logic [NW+CW-1:0] e;
        e = exp_q.pop_front();
        if ({commit_node, commit_chunk} != e) begin
          fails++;
          $display("FAIL R5 commit actual=%0d/%0d expected=%0d/%0d",
                   commit_node, commit_chunk, e[NW+CW-1:CW], e[CW-1:0]);
        end
      end
    end
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    step('1, 0, 0, 0, 0);
    step('1, 0, 0, 0, 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 assign", int'(assign_valid), 0);
    chk("R1 commit", int'(commit_valid), 0);
    @(negedge clk); rst_n = 1; req = '0; start = 1; total_chunks = 6'd10;
    @(negedge clk); start = 0;
    #1 chk("R10 empty after start", int'(empty), 0);

    step(3'b110, 0, 0, 0, 0); chk_assign(1, 0, "R2");
    step(3'b101, 0, 0, 0, 0); chk_assign(0, 1, "R2");
    step(3'b100, 0, 0, 0, 0); chk_assign(2, 2, "R2");
    step(3'b010, 0, 0, 0, 0); chk_assign(1, 3, "R2");
    step(3'b001, 0, 0, 0, 0); chk("R3 full hold", int'(assign_valid), 0);

    step(3'b000, 1, 2, 0, 0); chk("R6 early finish", int'(commit_valid), 0);
    step(3'b000, 1, 9, 0, 0); chk("R9 outside window", int'(commit_valid), 0);
    push(1, 0);
    step(3'b000, 1, 0, 0, 0);
    step(3'b000, 0, 0, 0, 0); chk("R6 unfinished head", int'(commit_valid), 0);
    step(3'b100, 0, 0, 0, 0); chk_assign(2, 4, "R7");
    push(0, 1); push(2, 2);
    step(3'b000, 1, 1, 0, 0);
    step(3'b000, 0, 0, 0, 0);
    step(3'b000, 0, 0, 0, 0); chk("R6 burst stops", int'(commit_valid), 0);

    step(3'b001, 0, 0, 1, 3);
    chk("R8 no assign in squash", int'(assign_valid), 0);
    chk("R8 no commit in squash", int'(commit_valid), 0);
    step(3'b001, 0, 0, 0, 0); chk_assign(0, 3, "R8");
    step(3'b010, 0, 0, 0, 0); chk_assign(1, 4, "R8");
    push(0, 3); step(3'b000, 1, 3, 0, 0);
    push(1, 4); step(3'b000, 1, 4, 0, 0);

    for (int c = 5; c < 10; c++) begin
      step(3'b001, 0, 0, 0, 0); chk_assign(0, c, "R2");
      chk("R10 busy", int'(empty), 0);
      push(0, c); step(3'b000, 1, c, 0, 0);
    end
    step(3'b111, 0, 0, 0, 0);
    chk("R4 total reached", int'(assign_valid), 0);
    chk("R10 empty at end", int'(empty), 1);
    step(3'b000, 0, 0, 0, 0);
    chk("R5 all commits seen", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule